// File: doc/BRIEF.md
# Skewed Bit-Pair Register File

This block is the operand storage of a linear systolic datapath whose words travel as a skewed wave: bit-pair i of a word is handled by slice i, one cycle after slice i-1. Each slice holds one two-bit column of every register, so every slice can reach its own bits without waiting for a central storage port.

An access is presented once, at slice 0, as an enable and a register number. The request then moves up the slices one per cycle, and each slice acts on its own bit-pair in step with the data wave. Write data arrives already skewed: pair i is taken from the write bus in the cycle the request reaches slice i. Read data leaves skewed in the same way.

A third access type streams one stored register out of slice 0 serially, least significant bit first, one bit per cycle. This stream feeds a bit-serial multiplier operand. Each slice loads its pair into an otherwise unused two-bit stage, and these stages shift right by one slice per cycle. Slice 0 sends out the low bit of each pair that arrives and then the high bit in the next cycle.

Top module: `skew_regfile`

## Requirements
- R1: The file holds NREG registers of W bits, eight registers of 16 bits by default, with slice i storing bits 2i+1 and 2i. When wr_en is high in cycle t, slice i stores wr_data[2i+1:2i] sampled in cycle t+i into register wr_addr. A cycle with wr_en low changes no stored bit, whatever wr_addr and wr_data hold.
- R2: When rd_en is high in cycle t, rd_data[2i+1:2i] shows bit-pair i of register rd_addr from cycle t+i+1.
- R3: A write and a read of the same register issued in the same cycle meet in every slice in the same cycle, and the read returns the old contents. A read issued one cycle after the write returns the new contents.
- R4: Each bit-pair of rd_data keeps its last value until a later read reaches that slice.
- R5: When ser_en is high in cycle t, ser_valid is high in cycles t+1 to t+W and ser_bit carries bit j of register ser_addr in cycle t+1+j. After that ser_valid falls, unless another request has been issued.
- R6: A serial request issued one cycle after a write to the same register streams the newly written value in every bit. A serial request issued in the same cycle as the write streams the old value.
- R7: A new serial request may be issued in the last valid cycle of the current stream, and the next stream then follows with no gap. A serial request is never issued at any other time while ser_valid is high.
- R8: After reset every register holds zero, rd_data is zero and ser_valid is low.
- R9: Reads, writes and serial requests to any registers may be issued in every cycle. Each request completes as R1, R2 and R5 state, whatever other requests are in flight on the slices at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Issue a write at slice 0 |
| wr_addr | input | $clog2(NREG) | Register to write |
| wr_data | input | W | Skewed write data; pair i is used i cycles after issue |
| rd_en | input | 1 | Issue a read at slice 0 |
| rd_addr | input | $clog2(NREG) | Register to read |
| rd_data | output | W | Skewed read data; pair i is valid i+1 cycles after issue |
| ser_en | input | 1 | Issue a serial extraction |
| ser_addr | input | $clog2(NREG) | Register to stream out |
| ser_bit | output | 1 | Serial operand bit, least significant bit first |
| ser_valid | output | 1 | ser_bit carries a stream bit |

## Verification
Directed writes, and then reads of every register, show whether the storage is arranged as described and whether the skew of each pair is correct. Writes paired with reads or serial requests to the same register, issued in the same cycle and one cycle later, separate the old value from the new one and expose a wrong slice-to-cycle alignment. Serial requests issued exactly W cycles apart show whether a pair collides with the next stream or arrives late. A long random mix, with all three access types in flight together, is compared every cycle against a model that works on whole words. It finds addresses that cross between requests and writes that happen when wr_en is low.

// File: rtl/skew_regfile.sv
module skew_regfile #(
  parameter int NREG = 8,
  parameter int W    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_addr,
  input  logic [W-1:0]             wr_data,
  input  logic                     rd_en,
  input  logic [$clog2(NREG)-1:0]  rd_addr,
  output logic [W-1:0]             rd_data,
  input  logic                     ser_en,
  input  logic [$clog2(NREG)-1:0]  ser_addr,
  output logic                     ser_bit,
  output logic                     ser_valid
);
  localparam int NS = W / 2;
  localparam int AW = $clog2(NREG);
  localparam int CW = $clog2(W + 1);

  logic [NS-1:0]      we_s, re_s, se_s;
  logic [AW-1:0]      wa_s [NS];
  logic [AW-1:0]      ra_s [NS];
  logic [AW-1:0]      sa_s [NS];
  logic [2*NREG-1:0]  mem  [NS];
  logic [1:0]         rdq  [NS];
  logic [1:0]         sh   [NS];
  logic               hi_q;
  logic [CW-1:0]      cnt;

  for (genvar i = 0; i < NS; i++) begin : g_slice
    if (i == 0) begin : g_head
      assign we_s[0] = wr_en;
      assign re_s[0] = rd_en;
      assign se_s[0] = ser_en;
      assign wa_s[0] = wr_addr;
      assign ra_s[0] = rd_addr;
      assign sa_s[0] = ser_addr;
    end else begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          we_s[i] <= 1'b0;
          re_s[i] <= 1'b0;
          se_s[i] <= 1'b0;
          wa_s[i] <= '0;
          ra_s[i] <= '0;
          sa_s[i] <= '0;
        end else begin
          we_s[i] <= we_s[i-1];
          re_s[i] <= re_s[i-1];
          se_s[i] <= se_s[i-1];
          wa_s[i] <= wa_s[i-1];
          ra_s[i] <= ra_s[i-1];
          sa_s[i] <= sa_s[i-1];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '0;
        rdq[i] <= '0;
      end else begin
        if (we_s[i]) mem[i][{wa_s[i], 1'b0} +: 2] <= wr_data[2*i +: 2];
        if (re_s[i]) rdq[i] <= mem[i][{ra_s[i], 1'b0} +: 2];
      end
    end

    if (i == NS - 1) begin : g_top
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh[i] <= '0;
        else        sh[i] <= se_s[i] ? mem[i][{sa_s[i], 1'b0} +: 2] : 2'b00;
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh[i] <= '0;
        else        sh[i] <= se_s[i] ? mem[i][{sa_s[i], 1'b0} +: 2] : sh[i+1];
      end
    end

    assign rd_data[2*i +: 2] = rdq[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hi_q <= 1'b0;
    end else begin
      hi_q <= sh[0][1];
      if (ser_en)         cnt <= CW'(W);
      else if (cnt != 0)  cnt <= cnt - 1'b1;
    end
  end

  assign ser_valid = (cnt != 0);
  assign ser_bit   = ser_valid & (cnt[0] ? hi_q : sh[0][0]);

  p_wr_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem[0]));
  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data[1:0]));
  p_ser_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |=> ser_valid);
  p_ser_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 1) && !ser_en |=> !ser_valid);
  p_ser_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> (cnt <= 1));
endmodule

// File: tb/test_skew_regfile.sv
module test_skew_regfile;
  localparam int NREG = 8;
  localparam int W    = 16;
  localparam int NS   = W / 2;
  localparam int AW   = $clog2(NREG);
  localparam int HMAX = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ser_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0, ser_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  rd_data;
  logic ser_bit, ser_valid;

  always #4 clk = ~clk;

  skew_regfile #(.NREG(NREG), .W(W)) i_skew_regfile (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ser_en(ser_en), .ser_addr(ser_addr),
    .ser_bit(ser_bit), .ser_valid(ser_valid));

  int total = 0, bad = 0;
  string tag = "R8";
  bit started = 0;

  bit h_we [HMAX];
  bit h_rd [HMAX];
  bit h_se [HMAX];
  int h_wa [HMAX];
  int h_ra [HMAX];
  int h_sa [HMAX];
  logic [W-1:0] snap [HMAX];
  logic [W-1:0] mm  [NREG];
  logic [W-1:0] old [NREG];
  logic [W-1:0] exp_rd;
  logic exp_sv, exp_sb;
  int c = 0;

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      c = 0;
      for (int r = 0; r < NREG; r++) mm[r] = '0;
      exp_rd = '0; exp_sv = 0; exp_sb = 0;
    end else if (c < HMAX) begin
      h_we[c] = wr_en; h_rd[c] = rd_en; h_se[c] = ser_en;
      h_wa[c] = int'(wr_addr); h_ra[c] = int'(rd_addr); h_sa[c] = int'(ser_addr);
      for (int r = 0; r < NREG; r++) old[r] = mm[r];
      for (int i = 0; i < NS; i++) begin
        if (c - i >= 0) begin
          if (h_rd[c-i]) exp_rd[2*i +: 2] = old[h_ra[c-i]][2*i +: 2];
          if (h_se[c-i]) snap[c-i][2*i +: 2] = old[h_sa[c-i]][2*i +: 2];
          if (h_we[c-i]) mm[h_wa[c-i]][2*i +: 2] = wr_data[2*i +: 2];
        end
      end
      exp_sv = 0; exp_sb = 0;
      for (int s = c; s >= 0 && s > c - W; s--) begin
        if (!exp_sv && h_se[s]) begin
          exp_sv = 1;
          exp_sb = snap[s][c - s];
        end
      end
      c++;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      total++;
      if (rd_data !== exp_rd) begin
        bad++;
        $display("FAIL %s rd_data got %h exp %h at cycle %0d", tag, rd_data, exp_rd, c);
      end
      total++;
      if (ser_valid !== exp_sv) begin
        bad++;
        $display("FAIL %s ser_valid got %b exp %b at cycle %0d", tag, ser_valid, exp_sv, c);
      end else if (exp_sv) begin
        total++;
        if (ser_bit !== exp_sb) begin
          bad++;
          $display("FAIL %s ser_bit got %b exp %b at cycle %0d", tag, ser_bit, exp_sb, c);
        end
      end
    end
  end

  int bcyc = 0;
  int last_ser = -100;

  task automatic drive(input bit we, input int wa, input bit re, input int ra,
                       input bit se, input int sa);
    @(negedge clk);
    wr_en = we; wr_addr = AW'(wa);
    rd_en = re; rd_addr = AW'(ra);
    ser_en = se; ser_addr = AW'(sa);
    wr_data = W'($urandom);
    if (se) last_ser = bcyc;
    bcyc++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      bad++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    tag = "R8";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    tag = "R1 R2";
    for (int r = 0; r < NREG; r++) drive(1, r, 0, 0, 0, 0);
    idle(NS);
    for (int r = 0; r < NREG; r++) drive(0, 0, 1, r, 0, 0);
    idle(NS + 2);
    for (int k = 0; k < 20; k++) drive(0, $urandom % NREG, 0, 0, 0, 0);
    for (int r = 0; r < NREG; r++) drive(0, 0, 1, r, 0, 0);
    idle(NS + 2);

    tag = "R3";
    drive(1, 3, 1, 3, 0, 0);
    drive(0, 0, 1, 3, 0, 0);
    idle(NS + 2);
    drive(1, 5, 1, 5, 0, 0);
    drive(1, 5, 1, 5, 0, 0);
    drive(0, 0, 1, 5, 0, 0);
    idle(NS + 2);

    tag = "R4";
    for (int k = 0; k < 12; k++) drive(1, $urandom % NREG, 0, 0, 0, 0);
    idle(NS + 2);

    tag = "R5 R6";
    drive(1, 2, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 2);
    idle(W + 2);
    drive(1, 6, 0, 0, 1, 6);
    idle(W + 2);
    drive(0, 0, 0, 0, 1, 6);
    idle(W + 2);

    tag = "R7";
    drive(0, 0, 0, 0, 1, 1);
    idle(W - 1);
    drive(0, 0, 0, 0, 1, 4);
    idle(W - 1);
    drive(1, 0, 0, 0, 1, 0);
    idle(W + 2);

    tag = "R9";
    for (int k = 0; k < 3000; k++) begin
      bit se;
      se = ((bcyc - last_ser) >= W) && ($urandom % 3 == 0);
      drive($urandom % 2, $urandom % NREG, $urandom % 2, $urandom % NREG,
            se, $urandom % NREG);
    end
    idle(W + NS + 4);
    finish_up();
  end
endmodule